// File: doc/BRIEF.md
# Double-Buffered Coefficient Bank with Column-Serial Readout

This block holds a set of fixed-point coefficients in two storage layers. A host writes the staging layer one whole word at a time over a parallel bus, selecting the word by a row address and a write strobe. The live layer drives one bit-serial line per coefficient. All lines step through the same bit column together, least significant bit first, and one word takes `WORD_W` clocks. The word stream repeats without gaps.

A host first stages a complete new coefficient set while the live set keeps streaming. It then raises a commit request. The block waits for the end of the word in flight and copies every staged word into the live layer on the same edge. Consumers therefore never see a mix of old and new coefficients, and never see a word that changed part way through. `NUM_REGS` is normally the number of processing elements plus a few spares. `WORD_W` is 32 for the signal format, which has a sign bit, two integer bits and 29 fraction bits.

Top module: `coef_bank`

## Requirements
- R1: A host write with `wr_en` high and `wr_addr` below `NUM_REGS` stores `wr_data` in the staging word at that row. It has no effect on `bit_out` until a later commit.
- R2: The column select steps through bit positions 0 up to `WORD_W-1` and then wraps to 0. In the k-th cycle of each word, every `bit_out[i]` carries bit k of live word i. `word_first` is high exactly in the cycle that carries bit 0.
- R3: A commit replaces all live words with the staged words on one edge, at the end of a word. The first word streamed after that edge carries the new values on every line.
- R4: A commit request arriving during a word is held, so a one-cycle pulse is enough. The request takes effect at the next word boundary, and the word in flight completes with the old values.
- R5: A commit copies the staging contents as they stood before the boundary edge. A host write in the boundary cycle lands only in the staging layer and reaches the outputs only at a later commit.
- R6: A write with `wr_addr` at or above `NUM_REGS` changes no stored word.
- R7: Synchronous active-high reset clears both layers, `bit_out` and the pending request, and restarts the column at bit 0. In the first cycle after reset release, `word_first` is high and all outputs are 0.
- R8: Without a commit, the live words stay unchanged, and the same word repeats on every line in each word period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | HOST_AW | Row of the staging word to write |
| wr_data | input | WORD_W | Coefficient value to stage |
| commit_req | input | 1 | Request to copy staging into live layer at next word boundary |
| bit_out | output | NUM_REGS | One serial line per coefficient, LSB first, registered |
| word_first | output | 1 | High while `bit_out` carries bit 0, registered |

## Verification
The hardest case to reach is a boundary cycle that holds both a pending commit and a host write to the same row. The staged value must go live, while the fresh write must stay staged.

To hit that cycle, the bench aligns on `word_first` and pulses the commit early in the word. It then issues the write in the exact cycle in which the second-to-last bit is on the lines. The following two words show first the old staged value and then, after another commit, the fresh one. Mid-word commits at every bit offset and out-of-range writes mixed into the streaming are swept as well.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;
  // width of an index able to hold values 0..n-1, never less than one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/coef_col_sel.sv
module coef_col_sel
  import coef_bank_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CW = idx_w(WORD_W)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] col,
  output logic          at_first,
  output logic          at_last
);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  assign at_last  = (col == LAST);
  assign at_first = (col == '0);

  always_ff @(posedge clk) begin
    if (rst)          col <= '0;
    else if (at_last) col <= '0;
    else              col <= col + 1'b1;
  end

  p_col_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    at_last |=> (col == '0));
  p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
    !at_last |=> (col == $past(col) + 1'b1));
endmodule

// File: rtl/coef_shadow.sv
module coef_shadow #(
  parameter int NUM_REGS = 12,
  parameter int WORD_W   = 32,
  parameter int HOST_AW  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [HOST_AW-1:0]               wr_addr,
  input  logic [WORD_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  stage
);
  // row decoder: out-of-range addresses match no row
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_row
    logic hit;
    assign hit = wr_en && (wr_addr == HOST_AW'(i));
    always_ff @(posedge clk) begin
      if (rst)      stage[i] <= '0;
      else if (hit) stage[i] <= wr_data;
    end
  end

  p_oob_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> $stable(stage));
  p_row_written_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_addr) < NUM_REGS)) |=> (stage[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/coef_active.sv
module coef_active
  import coef_bank_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int WORD_W   = 32,
  localparam int CW = idx_w(WORD_W)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             load,
  input  logic                             boundary,
  input  logic [NUM_REGS-1:0][WORD_W-1:0]  stage,
  input  logic [CW-1:0]                    col,
  output logic [NUM_REGS-1:0]              bit_out
);
  logic [NUM_REGS-1:0][WORD_W-1:0] live;

  always_ff @(posedge clk) begin
    if (rst)       live <= '0;
    else if (load) live <= stage;
  end

  // every row reads the same column; registered serial outputs
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) bit_out[i] <= 1'b0;
      else     bit_out[i] <= live[i][col];
    end
  end

  p_load_on_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    load |-> boundary);
  p_live_copy_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (live == $past(stage)));
  p_live_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(live));
endmodule

// File: rtl/coef_bank.sv
module coef_bank
  import coef_bank_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int WORD_W   = 32,
  parameter int HOST_AW  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [HOST_AW-1:0]   wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 commit_req,
  output logic [NUM_REGS-1:0]  bit_out,
  output logic                 word_first
);
  localparam int CW = idx_w(WORD_W);

  initial begin
    if (NUM_REGS > (1 << HOST_AW)) $error("coef_bank: HOST_AW too narrow for NUM_REGS");
    if (WORD_W < 2) $error("coef_bank: WORD_W must be at least 2");
  end

  logic [CW-1:0]                   col;
  logic                            at_first, at_last;
  logic [NUM_REGS-1:0][WORD_W-1:0] stage;
  logic                            pend;
  logic                            load;

  coef_col_sel #(.WORD_W(WORD_W)) u_col (
    .clk(clk), .rst(rst), .col(col), .at_first(at_first), .at_last(at_last)
  );

  coef_shadow #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .HOST_AW(HOST_AW)) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stage(stage)
  );

  // commit fires on the last column; earlier requests wait in pend
  assign load = at_last && (commit_req || pend);

  always_ff @(posedge clk) begin
    if (rst)             pend <= 1'b0;
    else if (load)       pend <= 1'b0;
    else if (commit_req) pend <= 1'b1;
  end

  coef_active #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_live (
    .clk(clk), .rst(rst), .load(load), .boundary(at_last),
    .stage(stage), .col(col), .bit_out(bit_out)
  );

  always_ff @(posedge clk) begin
    if (rst) word_first <= 1'b0;
    else     word_first <= at_first;
  end

  p_pend_set_r4: assert property (@(posedge clk) disable iff (rst)
    (commit_req && !at_last) |=> pend);
  p_pend_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (pend && at_last) |=> !pend);
  p_first_single_r2: assert property (@(posedge clk) disable iff (rst)
    word_first |=> !word_first);
endmodule

// File: tb/tb_coef_bank.sv
module tb_coef_bank;
  localparam int N  = 6;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          commit_req = 1'b0;
  logic [N-1:0]  bit_out;
  logic          word_first;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [N-1:0][W-1:0] exp_live, exp_stage, got;

  always #5 clk = ~clk;

  coef_bank #(.NUM_REGS(N), .WORD_W(W), .HOST_AW(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_req(commit_req), .bit_out(bit_out), .word_first(word_first)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic host_write(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < N) exp_stage[a] = d;
  endtask

  // Capture one full word from all lines. A commit pulse and one write can be
  // driven after sampling bit index commit_at / wr_at (seen at the following edge).
  task automatic capture(input int commit_at, input int wr_at, input int wa, input logic [W-1:0] wd);
    @(negedge clk);
    while (!word_first) @(negedge clk);
    for (int b = 0; b < W; b++) begin
      for (int i = 0; i < N; i++) got[i][b] = bit_out[i];
      if (b > 0) chk(word_first == 1'b0, "R2 word_first only on bit 0", 32'(word_first), 0);
      commit_req = (b == commit_at);
      wr_en = (b == wr_at);
      wr_addr = AW'(wa); wr_data = wd;
      @(negedge clk);
      commit_req = 1'b0; wr_en = 1'b0;
    end
    chk(word_first == 1'b1, "R2 word period", 32'(word_first), 1);
  endtask

  task automatic cmp_words(input string req);
    for (int i = 0; i < N; i++)
      chk(got[i] == exp_live[i], req, 32'(got[i]), 32'(exp_live[i]));
  endtask

  initial begin
    exp_live = '0; exp_stage = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: first cycle after release carries bit 0 of cleared words
    chk(word_first == 1'b1, "R7 word_first after reset", 32'(word_first), 1);
    chk(bit_out == '0, "R7 outputs zero after reset", 32'(bit_out), 0);

    // R2 / R3 / R4 sweep: stage arithmetic patterns, commit at every bit offset
    for (int r = 0; r < W; r++) begin
      for (int i = 0; i < N; i++)
        host_write(i, W'((i * 53 + r * 29 + 7) ^ (1 << ((i + r) % W))));
      // R6: out-of-range rows between real writes
      for (int a = N; a < (1 << AW); a++) host_write(a, W'(8'hA5 + a));
      capture(r, -1, 0, '0);
      cmp_words("R4 word in flight keeps old values");
      exp_live = exp_stage;
      capture(-1, -1, 0, '0);
      cmp_words("R3 new set live after boundary");
    end

    // R1 / R8: writes during streaming with no commit leave the stream alone
    for (int i = 0; i < N; i++) begin
      capture(-1, i + 1, i, W'(8'h3C + i));
      exp_stage[i] = W'(8'h3C + i);
      cmp_words("R1 streaming unaffected by write");
    end
    capture(-1, -1, 0, '0);
    cmp_words("R8 live words repeat without commit");

    // R6: out-of-range writes then commit: live equals staged set only
    host_write(N, 8'hFF);
    host_write((1 << AW) - 1, 8'h81);
    capture(1, -1, 0, '0);
    exp_live = exp_stage;
    capture(-1, -1, 0, '0);
    cmp_words("R6 out-of-range write ignored");

    // R5: pending commit plus a write to row 0 in the boundary cycle
    host_write(0, 8'h5A);
    capture(1, W - 2, 0, 8'hC3);
    exp_live = exp_stage;      // row 0 = 5A goes live
    exp_stage[0] = 8'hC3;
    capture(-1, -1, 0, '0);
    cmp_words("R5 boundary write stays staged");
    capture(0, -1, 0, '0);
    exp_live = exp_stage;
    capture(-1, -1, 0, '0);
    cmp_words("R5 boundary write live after next commit");

    // R4: repeated requests in one word make one transfer
    host_write(3, 8'h11);
    @(negedge clk); commit_req = 1'b1;
    repeat (3) @(negedge clk);
    commit_req = 1'b0;
    exp_live = exp_stage;
    capture(-1, -1, 0, '0);
    capture(-1, -1, 0, '0);
    cmp_words("R4 repeated request single transfer");

    // R2: LSB first, single set bit in bit 0 and bit W-1
    host_write(0, W'(1));
    host_write(1, W'(1) << (W - 1));
    capture(2, -1, 0, '0);
    exp_live = exp_stage;
    capture(-1, -1, 0, '0);
    chk(got[0] == W'(1), "R2 LSB first row 0", 32'(got[0]), 1);
    chk(got[1] == (W'(1) << (W - 1)), "R2 MSB last row 1", 32'(got[1]), 32'(W'(1) << (W - 1)));

    // R7: reset mid-stream clears both layers
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(word_first == 1'b1, "R7 column restarts", 32'(word_first), 1);
    chk(bit_out == '0, "R7 live cleared", 32'(bit_out), 0);
    exp_live = '0; exp_stage = '0;
    capture(0, -1, 0, '0);
    capture(-1, -1, 0, '0);
    cmp_words("R7 staging cleared");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule